// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital control logic that sets the state of a six-bit step attenuator. Control comes either from six parallel pins or from an eight-bit serial word. A mode pin chooses the path. A single latch-enable pin serves both paths. All pin inputs are asynchronous to the system clock. They pass through a synchronizer, and the block detects their edges in the clock domain before acting on them. Both paths write one registered attenuation output. The code 6'h3F is the maximum step, 31.5 dB, and 6'h00 is the insertion-loss state.

In parallel mode the latch-enable level selects the behaviour. With latch enable high the output tracks the pins, like a transparent latch. With latch enable low the output keeps the last value it captured. In serial mode, rising edges of the serial clock shift bits into an eight-bit register, least significant bit first. A falling edge on latch enable copies that register to the outputs. Word bits 5..0 form the attenuation code. Word bits 7..6 are control bits. Bit 7 must be cleared by a serial load before parallel operation is considered valid, and the block reports whether that has happened.

After reset the controller waits in `ST_BOOT` until the synchronizers have filled. If the pins then show parallel mode with latch enable high, it enters `ST_HOLD`. There it keeps maximum attenuation for a power-up interval computed from `CLK_HZ` and `HOLD_US`, and then moves to `ST_PAR`. Otherwise it goes straight to `ST_PAR` (mode low) or to `ST_SER` (mode high). The transitions `ST_PAR` to `ST_SER` and `ST_SER` to `ST_PAR` follow the synchronized mode pin at any time.

Top module: `stepatt_ctrl`

## Requirements
- R1: After reset with mode high, or with mode low and latch enable low, `atten_o` is 6'h3F, `hold_o` is 0, `par_ok_o` is 0 and `ctl_o` is 2'b11. The output keeps 6'h3F until a new word is captured.
- R2: If mode is low and latch enable is high when reset is released, `hold_o` is 1 and `atten_o` is 6'h3F for (CLK_HZ/1e6)*HOLD_US cycles after the boot wait. After that, `hold_o` drops and `atten_o` follows `par_i`.
- R3: In parallel mode with latch enable low, changes on `par_i` leave `atten_o` unchanged. A high-then-low pulse on latch enable leaves `atten_o` equal to `par_i` as it stood while latch enable was high.
- R4: In parallel mode with latch enable high, `atten_o` equals `par_i` no later than four clock cycles after `par_i` changes.
- R5: In serial mode each rising serial-clock edge shifts `ser_dat_i` into the top of the word. After eight edges, the first bit sent is word bit 0 and the last bit sent is word bit 7.
- R6: In serial mode, shifting while latch enable is low, and raising latch enable, leave `atten_o`, `ctl_o` and `par_ok_o` unchanged.
- R7: In serial mode a falling edge of latch enable sets `atten_o` to word bits 5..0 and `ctl_o` to word bits 7..6.
- R8: `par_ok_o` is set by a serial capture of a word whose bit 7 is 0. It is cleared by a serial capture of a word whose bit 7 is 1.
- R9: Mode low selects the parallel path and mode high selects the serial path. In serial mode `par_i` has no effect. In parallel mode serial-clock edges do not shift, so the serial word survives a trip through parallel mode.
- R10: If a latch-enable falling edge and a serial-clock rising edge are detected in the same cycle, the captured word is the content from before that shift. The shift still takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| mode_i | input | 1 | Path select: 0 parallel, 1 serial (asynchronous) |
| lat_en_i | input | 1 | Shared latch enable (asynchronous) |
| ser_clk_i | input | 1 | Serial shift clock, sampled for rising edges |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| par_i | input | 6 | Parallel attenuation code |
| atten_o | output | 6 | Registered attenuation state, 6'h3F = maximum |
| ctl_o | output | 2 | Control bits 7..6 of the last captured serial word |
| par_ok_o | output | 1 | High once a serial capture has cleared bit 7 |
| hold_o | output | 1 | High during the direct-mode power-up hold |

## Verification
Two functions can fall in the same cycle: the serial capture on a falling latch-enable edge and the shift on a rising serial-clock edge. The bench provokes this by driving both pins on the same clock edge, so both edges come out of the synchronizer together. It expects `atten_o` to show the word from before the shift. A second capture, with no new clock edge, must then show the shifted word, with its top bit computed in the bench. Exhaustive sweeps over all 256 serial words and all 64 parallel codes check the ordinary paths.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_HOLD = 2'd1,
        ST_PAR  = 2'd2,
        ST_SER  = 2'd3
    } att_state_t;

    // bit positions inside the synchronized input bundle
    localparam int unsigned IX_SDAT = 0;
    localparam int unsigned IX_SCK  = 1;
    localparam int unsigned IX_LE   = 2;
    localparam int unsigned IX_MODE = 3;
    localparam int unsigned IX_PAR  = 4;

endpackage

// File: rtl/stepatt_sync.sv
module stepatt_sync #(
    parameter int unsigned W      = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/stepatt_shreg.sv
module stepatt_shreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_o <= '1;
        else if (shift_i) word_o <= {din_i, word_o[W-1:1]};
    end

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (word_o[W-1] == $past(din_i)) && (word_o[W-2:0] == $past(word_o[W-1:1]))); // R5
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(word_o)); // R9
endmodule

// File: rtl/stepatt_fsm.sv
module stepatt_fsm
    import stepatt_pkg::*;
#(
    parameter int unsigned ATT_W    = 6,
    parameter int unsigned WORD_W   = 8,
    parameter int unsigned BOOT_CYC = 3,
    parameter int unsigned HOLD_CYC = 50000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_s,
    input  logic                     le_s,
    input  logic                     sck_s,
    input  logic [ATT_W-1:0]         par_s,
    input  logic [WORD_W-1:0]        word_i,
    output logic                     shift_o,
    output logic [ATT_W-1:0]         atten_o,
    output logic [WORD_W-ATT_W-1:0]  ctl_o,
    output logic                     par_ok_o,
    output logic                     hold_o
);
    localparam int unsigned CTL_W  = WORD_W - ATT_W;
    localparam int unsigned CNT_MX = (HOLD_CYC > BOOT_CYC) ? HOLD_CYC : BOOT_CYC;
    localparam int unsigned CNT_W  = $clog2(CNT_MX + 1);
    localparam logic [CNT_W-1:0] BOOT_LAST = CNT_W'(BOOT_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [ATT_W-1:0] ATT_MAX   = '1;

    att_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic             le_q, sck_q;
    logic             le_fall, sck_rise;

    // edge history of the synchronized strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            le_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            le_q  <= le_s;
            sck_q <= sck_s;
        end
    end

    assign le_fall  = le_q & ~le_s;
    assign sck_rise = sck_s & ~sck_q;
    assign shift_o  = sck_rise && (st == ST_SER);
    assign hold_o   = (st == ST_HOLD);

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_BOOT: if (cnt == BOOT_LAST) begin
                         if (mode_s)    st_nx = ST_SER;
                         else if (le_s) st_nx = ST_HOLD;
                         else           st_nx = ST_PAR;
                     end
            ST_HOLD: if (cnt == HOLD_LAST) st_nx = mode_s ? ST_SER : ST_PAR;
            ST_PAR:  if (mode_s)  st_nx = ST_SER;
            ST_SER:  if (!mode_s) st_nx = ST_PAR;
            default: st_nx = ST_BOOT;
        endcase
    end

    // state register and interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_BOOT;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st)                          cnt <= '0;
            else if (st == ST_BOOT || st == ST_HOLD)  cnt <= cnt + 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            atten_o  <= ATT_MAX;
            ctl_o    <= '1;
            par_ok_o <= 1'b0;
        end else begin
            unique case (st)
                ST_BOOT, ST_HOLD: atten_o <= ATT_MAX;
                ST_PAR:  if (le_s) atten_o <= par_s;
                ST_SER:  if (le_fall) begin
                             atten_o  <= word_i[ATT_W-1:0];
                             ctl_o    <= word_i[WORD_W-1:ATT_W];
                             par_ok_o <= ~word_i[WORD_W-1];
                         end
                default: atten_o <= ATT_MAX;
            endcase
        end
    end

    AST_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |=> (atten_o == ATT_MAX)); // R2
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (cnt < CNT_W'(HOLD_CYC))); // R2
    AST_LAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAR && !le_s) |=> $stable(atten_o)); // R3
    AST_DIR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAR && le_s) |=> (atten_o == $past(par_s))); // R4
    AST_SER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SER && !le_fall) |=> ($stable(atten_o) && $stable(ctl_o) && $stable(par_ok_o))); // R6
    AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SER && le_fall) |=> (atten_o == $past(word_i[ATT_W-1:0]))); // R7
    AST_OK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SER && le_fall) |=> (par_ok_o == !$past(word_i[WORD_W-1]))); // R8
    AST_NO_PAR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_SER) |-> !shift_o); // R9
    AST_CTL_W: assert final (CTL_W >= 1); // R7
endmodule

// File: rtl/stepatt_ctrl.sv
module stepatt_ctrl
    import stepatt_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned HOLD_US     = 400,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ATT_W       = 6,
    parameter int unsigned WORD_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_i,
    input  logic                    lat_en_i,
    input  logic                    ser_clk_i,
    input  logic                    ser_dat_i,
    input  logic [ATT_W-1:0]        par_i,
    output logic [ATT_W-1:0]        atten_o,
    output logic [WORD_W-ATT_W-1:0] ctl_o,
    output logic                    par_ok_o,
    output logic                    hold_o
);
    localparam int unsigned BUS_W    = IX_PAR + ATT_W;
    localparam int unsigned HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;
    localparam int unsigned BOOT_CYC = SYNC_STAGES + 1;

    logic [BUS_W-1:0]  raw, syn;
    logic [WORD_W-1:0] word;
    logic              shift;

    assign raw = {par_i, mode_i, lat_en_i, ser_clk_i, ser_dat_i};

    stepatt_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    stepatt_shreg #(.W(WORD_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift),
        .din_i   (syn[IX_SDAT]),
        .word_o  (word)
    );

    stepatt_fsm #(
        .ATT_W    (ATT_W),
        .WORD_W   (WORD_W),
        .BOOT_CYC (BOOT_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_s   (syn[IX_MODE]),
        .le_s     (syn[IX_LE]),
        .sck_s    (syn[IX_SCK]),
        .par_s    (syn[IX_PAR +: ATT_W]),
        .word_i   (word),
        .shift_o  (shift),
        .atten_o  (atten_o),
        .ctl_o    (ctl_o),
        .par_ok_o (par_ok_o),
        .hold_o   (hold_o)
    );
endmodule

// File: tb/stepatt_ctrl_test.sv
`timescale 1ns/1ps
module stepatt_ctrl_test;
    localparam int HOLD = 400;   // (1 MHz / 1e6) * 400 us

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b1, le = 1'b0, sck = 1'b0, sdat = 1'b0;
    logic [5:0] par = 6'h00;
    logic [5:0] atten;
    logic [1:0] ctl;
    logic       pok, hold;
    int         tests = 0, fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    stepatt_ctrl #(.CLK_HZ(1_000_000), .HOLD_US(400)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .lat_en_i(le),
        .ser_clk_i(sck), .ser_dat_i(sdat), .par_i(par),
        .atten_o(atten), .ctl_o(ctl), .par_ok_o(pok), .hold_o(hold)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic m, input logic l, input logic [5:0] p);
        rst_n = 1'b0; mode = m; le = l; par = p; sck = 1'b0; sdat = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    // shift a word LSB first, leaving latch enable low
    task automatic shift_word(input logic [7:0] w);
        for (int i = 0; i < 8; i++) begin
            sdat = w[i]; tick(4);
            sck = 1'b1;  tick(4);
            sck = 1'b0;  tick(2);
        end
    endtask

    task automatic pulse_le();
        le = 1'b1; tick(5);
        le = 1'b0; tick(6);
    endtask

    initial begin
        logic [7:0] w, prev;
        logic [5:0] kept;
        // R1: serial power-up
        do_reset(1'b1, 1'b0, 6'h00);
        tick(8);
        chk("R1 atten serial", {2'b0, atten}, 8'h3F);
        chk("R1 hold", {7'b0, hold}, 8'h00);
        chk("R1 par_ok", {7'b0, pok}, 8'h00);
        chk("R1 ctl", {6'b0, ctl}, 8'h03);
        par = 6'h15; tick(6);
        chk("R9 par ignored in serial", {2'b0, atten}, 8'h3F);

        // R5 R6 R7 R8: all serial words
        prev = 8'hFF;
        for (int k = 0; k < 256; k++) begin
            w = 8'(k ^ 8'h5A);
            shift_word(w);
            le = 1'b1; tick(6);
            chk("R6 no change before capture", {2'b0, atten}, {2'b0, prev[5:0]});
            le = 1'b0; tick(6);
            chk("R5 R7 atten", {2'b0, atten}, {2'b0, w[5:0]});
            chk("R7 ctl", {6'b0, ctl}, {6'b0, w[7:6]});
            chk("R8 par_ok", {7'b0, pok}, {7'b0, ~w[7]});
            prev = w;
        end

        // R10: capture and shift in the same cycle
        w = 8'h4B;
        shift_word(w); pulse_le();
        sdat = 1'b1; le = 1'b1; tick(6);
        le = 1'b0; sck = 1'b1; tick(6);
        chk("R10 captured pre-shift word", {2'b0, atten}, {2'b0, w[5:0]});
        sck = 1'b0; tick(4);
        pulse_le();
        prev = {1'b1, w[7:1]};
        chk("R10 shift still applied", {2'b0, atten}, {2'b0, prev[5:0]});
        chk("R10 ctl", {6'b0, ctl}, {6'b0, prev[7:6]});
        chk("R8 cleared by D7 high", {7'b0, pok}, 8'h00);

        // R9: serial word survives parallel mode
        w = 8'h27;
        shift_word(w); pulse_le();
        mode = 1'b0; tick(6);
        par = 6'h11; tick(6);
        chk("R3 R9 keep after mode change", {2'b0, atten}, {2'b0, w[5:0]});
        shift_word(8'hC0);
        mode = 1'b1; tick(6);
        pulse_le();
        chk("R9 no shift in parallel", {2'b0, atten}, {2'b0, w[5:0]});
        chk("R9 ctl kept", {6'b0, ctl}, {6'b0, w[7:6]});

        // R3: latched parallel sweep
        mode = 1'b0; tick(6);
        kept = atten;
        for (int v = 0; v < 64; v++) begin
            par = 6'(v * 37 + 5); tick(6);
            chk("R3 hold while LE low", {2'b0, atten}, {2'b0, kept});
            le = 1'b1; tick(5); le = 1'b0; tick(2);
            par = ~par; tick(6);
            kept = 6'(v * 37 + 5);
            chk("R3 latched value", {2'b0, atten}, {2'b0, kept});
        end

        // R4: direct parallel sweep
        le = 1'b1;
        for (int v = 0; v < 64; v++) begin
            par = 6'(v); tick(5);
            chk("R4 follow", {2'b0, atten}, 8'(v));
        end

        // R2: direct-mode power-up hold
        do_reset(1'b0, 1'b1, 6'h2A);
        tick(6);
        chk("R2 hold active", {7'b0, hold}, 8'h01);
        chk("R2 max during hold", {2'b0, atten}, 8'h3F);
        tick(HOLD - 6);
        chk("R2 hold still active", {7'b0, hold}, 8'h01);
        chk("R2 max late in hold", {2'b0, atten}, 8'h3F);
        tick(10);
        chk("R2 hold ended", {7'b0, hold}, 8'h00);
        chk("R2 follows pins", {2'b0, atten}, 8'h2A);

        // R1: latched-parallel power-up
        do_reset(1'b0, 1'b0, 6'h07);
        tick(8);
        chk("R1 atten latched", {2'b0, atten}, 8'h3F);
        chk("R1 no hold", {7'b0, hold}, 8'h00);
        par = 6'h01; tick(6);
        chk("R1 stays max", {2'b0, atten}, 8'h3F);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule